// File: doc/BRIEF.md
# Static Memory Cycle Sequencer

This block produces the strobe pattern for a single static-memory chip select: SRAM, flash and similar devices with a plain chip-select, read-strobe and write-strobe interface. A requester presents one access: a two-bit byte offset, a size and a direction. The sequencer then walks the bus cycle clock by clock. It drives an active-low chip select, an output enable, a write enable and four byte-lane enables, and it marks the final clock of the access with a one-clock done pulse.

The option inputs control the shape of the cycle:
- the number of wait clocks;
- asynchronous or clock-synchronous strobe timing, chosen separately for reads and writes;
- the width of the attached port;
- whether an external acknowledge input ends the wait phase;
- an optional dead clock after each cycle;
- fixed-length bursts with a programmable beat length and beat count.

The options are captured when an access is accepted and stay fixed until that access ends. An access that is wider than the port is split into several bus cycles. They run from the lowest byte address upward, and the current sub-cycle's low address bits are shown on `cyc_addr`.

Top module: `static_cycle_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, `cs_n`, `oe_n`, `we_n` and all of `be_n` are high, and `busy` and `done` are low.
- R2: A bus cycle holds `cs_n` low for 2 + N clocks, where N is `cfg_wait`. When the strobe mode of the access is asynchronous, N is at least 1, so a `cfg_wait` of 0 gives the same cycle as 1.
- R3: In asynchronous mode the strobe is low in every clock of the bus cycle except the first. In synchronous mode it is low only in the first clock. The strobe is `oe_n` for reads and `we_n` for writes. The mode is `cfg_rsync` for reads and `cfg_wsync` for writes (1 = synchronous), and `oe_n` and `we_n` are never low together.
- R4: `req_size` is coded 00 byte, 01 halfword, 10 word. On a 32-bit port (`cfg_ps` 00), byte offset k drives `be_n[k]` low, and one bus cycle carries the whole access with `cyc_addr` equal to its lowest byte offset.
- R5: On a 16-bit port (`cfg_ps` 01), only lanes `be_n[3:2]` are used. Each halfword that the access touches gets its own bus cycle, lower halfword first. Byte k of a halfword drives `be_n[2+k]`, and `cyc_addr` is 0 or 2.
- R6: On an 8-bit port (`cfg_ps` 10), only `be_n[3]` is used. Each byte that the access touches gets its own bus cycle in ascending address order, with `cyc_addr` equal to that byte's offset.
- R7: With `cfg_ps` 11 (32-bit port, acknowledged cycle), `cfg_wait` is ignored. The cycle stays in its wait phase, at least one clock long, until `ext_ta` is sampled high, and the final clock follows.
- R8: With `cfg_idle` set, one clock with `cs_n` high and `busy` high follows every bus cycle and the end of every burst.
- R9: When `cfg_burst` and `req_burst` are both set, the access is a burst of 2 << `cfg_bsize` port-width beats, with `cyc_addr` 0. The first beat is a normal bus cycle. Each later beat lasts `cfg_bcyc` + 1 clocks, with the strobe held for the whole beat in asynchronous mode and for its first clock in synchronous mode. If `cfg_burst` is clear, `req_burst` has no effect.
- R10: `done` is high for exactly one clock: the last clock with `cs_n` low in the access.
- R11: A `req` presented while `busy` is high is ignored, and the running access continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, accepted when not busy |
| req_addr | input | 2 | Byte offset within the word |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | Ask for a burst access |
| cfg_wait | input | WAIT_W | Wait clocks per bus cycle |
| cfg_ps | input | 2 | Port: 00 32-bit, 01 16-bit, 10 8-bit, 11 32-bit acknowledged |
| cfg_idle | input | 1 | Dead clock after each cycle |
| cfg_burst | input | 1 | Burst enable |
| cfg_bcyc | input | BCYC_W | Later burst beat length minus one |
| cfg_bsize | input | BSIZE_W | Burst beats = 2 << value |
| cfg_rsync | input | 1 | Synchronous read strobe |
| cfg_wsync | input | 1 | Synchronous write strobe |
| ext_ta | input | 1 | External transfer acknowledge, active high |
| busy | output | 1 | Access in progress |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_n | output | 4 | Byte-lane enables, active low |
| cyc_addr | output | 2 | Low address bits of the current bus cycle |
| done | output | 1 | Last clock of the access |

## Verification
The hardest situation to reach from the ports is a request that arrives while an access is running. Two further combinations are also hard to produce: a split access combined with dead clocks, and an acknowledged cycle whose wait phase depends on when `ext_ta` rises. The bench first builds the whole expected per-clock trace of an access. Each entry of that trace also holds the `ext_ta` value to drive in that clock, so the acknowledge delay is chosen per test. During chosen accesses the bench holds `req` high with different address, size and direction. The trace must still come out unchanged, which shows that the stray request was ignored.

// File: rtl/static_cycle_seq.sv
module static_cycle_seq #(
  parameter int WAIT_W  = 4,
  parameter int BCYC_W  = 2,
  parameter int BSIZE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [1:0]         req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_write,
  input  logic               req_burst,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [1:0]         cfg_ps,
  input  logic               cfg_idle,
  input  logic               cfg_burst,
  input  logic [BCYC_W-1:0]  cfg_bcyc,
  input  logic [BSIZE_W-1:0] cfg_bsize,
  input  logic               cfg_rsync,
  input  logic               cfg_wsync,
  input  logic               ext_ta,
  output logic               busy,
  output logic               cs_n,
  output logic               oe_n,
  output logic               we_n,
  output logic [3:0]         be_n,
  output logic [1:0]         cyc_addr,
  output logic               done
);
  localparam int MAXB   = 2 << ((1 << BSIZE_W) - 1);
  localparam int BEAT_W = $clog2(MAXB) + 1;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_TW, S_T2, S_BT, S_TI} st_t;

  st_t               st;
  logic [WAIT_W-1:0] wcnt, wait_q;
  logic [BCYC_W-1:0] bcnt, bcyc_q;
  logic [BEAT_W-1:0] bleft;
  logic [3:0]        rem, rmask, cur, lanes, plane, rem_nx;
  logic [1:0]        ps_q, lo;
  logic              wr_q, sync_q, idle_q, burst_q, sel_sync, active, strobe, fin;

  wire ta_mode = (ps_q == 2'b11);

  always_comb begin
    case (req_size)
      2'b00:   rmask = 4'b0001 << req_addr;
      2'b01:   rmask = req_addr[1] ? 4'b1100 : 4'b0011;
      default: rmask = 4'b1111;
    endcase
  end

  always_comb begin
    case (ps_q)
      2'b10:   cur = rem & (~rem + 4'd1);
      2'b01:   cur = (|rem[1:0]) ? {2'b00, rem[1:0]} : {rem[3:2], 2'b00};
      default: cur = rem;
    endcase
  end

  always_comb begin
    if (cur[0])      lo = 2'd0;
    else if (cur[1]) lo = 2'd1;
    else if (cur[2]) lo = 2'd2;
    else             lo = 2'd3;
  end

  always_comb begin
    case (ps_q)
      2'b10:   begin lanes = 4'b1000;                          plane = 4'b1000; end
      2'b01:   begin lanes = {cur[1:0] | cur[3:2], 2'b00};     plane = 4'b1100; end
      default: begin lanes = cur;                              plane = 4'b1111; end
    endcase
  end

  assign rem_nx   = rem & ~cur;
  assign sel_sync = req_write ? cfg_wsync : cfg_rsync;
  assign fin      = (st == S_BT) && (bcnt == '0) && (bleft == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wcnt    <= '0;
      wait_q  <= '0;
      bcnt    <= '0;
      bcyc_q  <= '0;
      bleft   <= '0;
      rem     <= '0;
      ps_q    <= 2'b00;
      wr_q    <= 1'b0;
      sync_q  <= 1'b0;
      idle_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st      <= S_T1;
          ps_q    <= cfg_ps;
          wr_q    <= req_write;
          sync_q  <= sel_sync;
          idle_q  <= cfg_idle;
          bcyc_q  <= cfg_bcyc;
          burst_q <= cfg_burst && req_burst;
          wait_q  <= (!sel_sync && cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;
          bleft   <= BEAT_W'((2 << cfg_bsize) - 1);
          rem     <= (cfg_burst && req_burst) ? 4'b0000 : rmask;
        end
        S_T1: begin
          if (ta_mode || wait_q != '0) begin
            st   <= S_TW;
            wcnt <= wait_q - WAIT_W'(1);
          end else begin
            st <= S_T2;
          end
        end
        S_TW: begin
          if (ta_mode ? ext_ta : (wcnt == '0)) st <= S_T2;
          else wcnt <= wcnt - WAIT_W'(1);
        end
        S_T2: begin
          if (burst_q) begin
            st    <= S_BT;
            bcnt  <= bcyc_q;
            bleft <= bleft - BEAT_W'(1);
          end else if (rem_nx != 4'b0000) begin
            rem <= rem_nx;
            st  <= idle_q ? S_TI : S_T1;
          end else begin
            rem <= 4'b0000;
            st  <= idle_q ? S_TI : S_IDLE;
          end
        end
        S_BT: begin
          if (bcnt == '0) begin
            if (bleft == '0) begin
              st <= idle_q ? S_TI : S_IDLE;
            end else begin
              bleft <= bleft - BEAT_W'(1);
              bcnt  <= bcyc_q;
            end
          end else begin
            bcnt <= bcnt - BCYC_W'(1);
          end
        end
        S_TI:    st <= (rem != 4'b0000) ? S_T1 : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active = (st == S_T1) || (st == S_TW) || (st == S_T2) || (st == S_BT);
  assign strobe = sync_q ? ((st == S_T1) || (st == S_BT && bcnt == bcyc_q))
                         : ((st == S_TW) || (st == S_T2) || (st == S_BT));

  assign busy     = (st != S_IDLE);
  assign cs_n     = !active;
  assign oe_n     = !(strobe && !wr_q);
  assign we_n     = !(strobe && wr_q);
  assign be_n     = active ? ~(burst_q ? plane : lanes) : 4'hf;
  assign cyc_addr = (active && !burst_q) ? ((ps_q == 2'b01) ? {lo[1], 1'b0} : lo) : 2'b00;
  assign done     = ((st == S_T2) && !burst_q && rem_nx == 4'b0000) || fin;

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (be_n == 4'hf && oe_n && we_n && !done));
  a_r2_async_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1 && !sync_q) |=> (st == S_TW));
  a_r5_half_upper_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ps_q == 2'b01) |-> (be_n[1:0] == 2'b11));
  a_r6_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ps_q == 2'b10) |-> (be_n == 4'b0111));
  a_r7_ta_holds_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW && ta_mode && !ext_ta) |=> (st == S_TW && !cs_n));
  a_r8_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && idle_q) |=> (cs_n && busy));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_static_cycle_seq.sv
module sim_static_cycle_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0, req_burst = 1'b0, ext_ta = 1'b0;
  logic [1:0] req_addr = 2'b00, req_size = 2'b00, cfg_ps = 2'b00;
  logic [3:0] cfg_wait = 4'd2;
  logic cfg_idle = 1'b0, cfg_burst = 1'b0, cfg_rsync = 1'b0, cfg_wsync = 1'b0;
  logic [1:0] cfg_bcyc = 2'd0, cfg_bsize = 2'd0;
  logic busy, cs_n, oe_n, we_n, done;
  logic [3:0] be_n;
  logic [1:0] cyc_addr;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  typedef struct packed {
    logic cs, oe, we; logic [3:0] be; logic [1:0] ad; logic dn, bz, ta;
  } ev_t;
  ev_t q[$];

  static_cycle_seq u0 (
    .clk, .rst_n, .req, .req_addr, .req_size, .req_write, .req_burst,
    .cfg_wait, .cfg_ps, .cfg_idle, .cfg_burst, .cfg_bcyc, .cfg_bsize,
    .cfg_rsync, .cfg_wsync, .ext_ta, .busy, .cs_n, .oe_n, .we_n, .be_n,
    .cyc_addr, .done);

  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  task automatic push(input logic act, stb, wr, input logic [3:0] be,
                      input logic [1:0] ad, input logic dn, tav);
    ev_t e;
    e.cs = !act; e.oe = !(act && stb && !wr); e.we = !(act && stb && wr);
    e.be = act ? ~be : 4'hf; e.ad = ad; e.dn = dn; e.bz = 1'b1; e.ta = tav;
    q.push_back(e);
  endtask

  task automatic unit(input logic wr, sy, input logic [3:0] be,
                      input logic [1:0] ad, input logic last, input int tad);
    int w;
    logic tam = (cfg_ps == 2'b11);
    w = tam ? tad + 1 : ((!sy && cfg_wait == 0) ? 1 : int'(cfg_wait));
    for (int i = 0; i <= w + 1; i++)
      push(1'b1, sy ? (i == 0) : (i > 0), wr, be, ad, last && (i == w + 1), tam && (i == w));
  endtask

  task automatic build(input logic wr, input logic [1:0] a, sz, input logic br, input int tad);
    logic sy = wr ? cfg_wsync : cfg_rsync;
    logic [3:0] m, pl;
    int nb, cnt, k;
    q.delete();
    m = (sz == 2'b00) ? (4'b0001 << a) : (sz == 2'b01) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    pl = (cfg_ps == 2'b10) ? 4'b1000 : (cfg_ps == 2'b01) ? 4'b1100 : 4'b1111;
    if (cfg_burst && br) begin
      nb = 2 << cfg_bsize;
      unit(wr, sy, pl, 2'b00, 1'b0, tad);
      for (int b = 1; b < nb; b++)
        for (int c = 0; c <= int'(cfg_bcyc); c++)
          push(1'b1, sy ? (c == 0) : 1'b1, wr, pl, 2'b00, (b == nb - 1) && (c == int'(cfg_bcyc)), 1'b0);
      if (cfg_idle) push(1'b0, 1'b0, wr, 4'h0, 2'b00, 1'b0, 1'b0);
    end else if (cfg_ps == 2'b01) begin
      cnt = (|m[1:0]) + (|m[3:2]); k = 0;
      for (int h = 0; h < 2; h++) if (m[2*h +: 2] != 2'b00) begin
        k++;
        unit(wr, sy, {m[2*h +: 2], 2'b00}, 2'(2*h), k == cnt, tad);
        if (cfg_idle) push(1'b0, 1'b0, wr, 4'h0, 2'b00, 1'b0, 1'b0);
      end
    end else if (cfg_ps == 2'b10) begin
      cnt = $countones(m); k = 0;
      for (int j = 0; j < 4; j++) if (m[j]) begin
        k++;
        unit(wr, sy, 4'b1000, 2'(j), k == cnt, tad);
        if (cfg_idle) push(1'b0, 1'b0, wr, 4'h0, 2'b00, 1'b0, 1'b0);
      end
    end else begin
      k = m[0] ? 0 : m[1] ? 1 : m[2] ? 2 : 3;
      unit(wr, sy, m, 2'(k), 1'b1, tad);
      if (cfg_idle) push(1'b0, 1'b0, wr, 4'h0, 2'b00, 1'b0, 1'b0);
    end
  endtask

  task automatic cmp(input string tag, input ev_t e);
    n_cmp++;
    if (cs_n !== e.cs || oe_n !== e.oe || we_n !== e.we || be_n !== e.be ||
        done !== e.dn || busy !== e.bz || (!e.cs && cyc_addr !== e.ad)) begin
      n_bad++;
      $display("FAIL %s: actual cs%b oe%b we%b be%b ad%0d dn%b bz%b expected cs%b oe%b we%b be%b ad%0d dn%b bz%b",
               tag, cs_n, oe_n, we_n, be_n, cyc_addr, done, busy,
               e.cs, e.oe, e.we, e.be, e.ad, e.dn, e.bz);
    end
  endtask

  task automatic run(input string tag, input logic wr, input logic [1:0] a, sz,
                     input logic br, input int tad, input logic stray);
    ev_t idle_e;
    int len;
    build(wr, a, sz, br, tad);
    len = q.size();
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_burst = br;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cmp(tag, q[i]);
      ext_ta = q[i].ta;
      req = stray;
      if (stray) begin req_write = !wr; req_addr = ~a; req_size = 2'b10; req_burst = !br; end
    end
    @(negedge clk);
    req = 1'b0; ext_ta = 1'b0;
    idle_e = '{cs:1'b1, oe:1'b1, we:1'b1, be:4'hf, ad:2'b00, dn:1'b0, bz:1'b0, ta:1'b0};
    cmp({tag, " end"}, idle_e);
  endtask

  initial begin
    ev_t r;
    r = '{cs:1'b1, oe:1'b1, we:1'b1, be:4'hf, ad:2'b00, dn:1'b0, bz:1'b0, ta:1'b0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset", r);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 idle", r);

    cfg_ps = 2'b00; cfg_wait = 4'd2;
    run("R4 word read", 1'b0, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    run("R4 byte write at 2", 1'b1, 2'd2, 2'b00, 1'b0, 0, 1'b0);
    run("R4 half read at 2", 1'b0, 2'd2, 2'b01, 1'b0, 0, 1'b0);
    cfg_wait = 4'd0;
    run("R2 async wait0", 1'b0, 2'd1, 2'b00, 1'b0, 0, 1'b0);
    cfg_wait = 4'd1;
    run("R2 async wait1", 1'b1, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    cfg_wait = 4'd3;
    run("R2 async wait3", 1'b1, 2'd3, 2'b00, 1'b0, 0, 1'b0);
    cfg_rsync = 1'b1; cfg_wait = 4'd0;
    run("R3 sync read wait0", 1'b0, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    cfg_wsync = 1'b1; cfg_wait = 4'd5;
    run("R3 sync write wait5", 1'b1, 2'd0, 2'b01, 1'b0, 0, 1'b0);
    cfg_rsync = 1'b0; cfg_wsync = 1'b0; cfg_wait = 4'd1;

    cfg_ps = 2'b01;
    run("R5 word on 16", 1'b0, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    run("R5 byte 3 on 16", 1'b1, 2'd3, 2'b00, 1'b0, 0, 1'b0);
    run("R5 half 0 on 16", 1'b0, 2'd0, 2'b01, 1'b0, 0, 1'b0);
    cfg_ps = 2'b10;
    run("R6 word on 8", 1'b1, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    run("R6 half 2 on 8", 1'b0, 2'd2, 2'b01, 1'b0, 0, 1'b0);

    cfg_ps = 2'b11; cfg_wait = 4'd7;
    run("R7 ta immediate", 1'b0, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    run("R7 ta delay3", 1'b1, 2'd1, 2'b00, 1'b0, 3, 1'b0);
    cfg_wsync = 1'b1;
    run("R7 ta sync write", 1'b1, 2'd0, 2'b10, 1'b0, 2, 1'b0);
    cfg_wsync = 1'b0; cfg_wait = 4'd2;

    cfg_idle = 1'b1; cfg_ps = 2'b10;
    run("R8 idle split 8", 1'b0, 2'd0, 2'b10, 1'b0, 0, 1'b0);
    cfg_ps = 2'b00;
    run("R8 idle 32", 1'b1, 2'd2, 2'b01, 1'b0, 0, 1'b0);
    cfg_idle = 1'b0;

    cfg_burst = 1'b1; cfg_bsize = 2'd0; cfg_bcyc = 2'd0;
    run("R9 burst 2x1", 1'b0, 2'd0, 2'b10, 1'b1, 0, 1'b0);
    cfg_bsize = 2'd1; cfg_bcyc = 2'd2; cfg_rsync = 1'b1;
    run("R9 burst 4x3 sync", 1'b0, 2'd0, 2'b10, 1'b1, 0, 1'b0);
    cfg_rsync = 1'b0; cfg_ps = 2'b01; cfg_idle = 1'b1; cfg_bsize = 2'd2; cfg_bcyc = 2'd1;
    run("R9 burst 8 on 16 idle", 1'b1, 2'd0, 2'b10, 1'b1, 0, 1'b0);
    cfg_idle = 1'b0; cfg_ps = 2'b11; cfg_bsize = 2'd3; cfg_bcyc = 2'd0;
    run("R9 burst 16 ta", 1'b0, 2'd0, 2'b10, 1'b1, 1, 1'b0);
    cfg_burst = 1'b0; cfg_ps = 2'b00;
    run("R9 burst disabled", 1'b0, 2'd1, 2'b00, 1'b1, 0, 1'b0);

    run("R11 stray req 32", 1'b0, 2'd0, 2'b01, 1'b0, 0, 1'b1);
    cfg_ps = 2'b10; cfg_idle = 1'b1;
    run("R11 stray req split", 1'b1, 2'd0, 2'b01, 1'b0, 0, 1'b1);
    cfg_idle = 1'b0;
    run("R10 done single", 1'b0, 2'd2, 2'b00, 1'b0, 0, 1'b0);

    summary();
  end
endmodule